// File: doc/BRIEF.md
# Accelerator Handoff Control Unit

This unit is the processor-side controller that passes execution to a tightly-coupled accelerator and takes it back. It watches the instruction word in the decode stage for two custom instructions in the custom-0 opcode space. Both instructions use the I-type layout, and only the funct3 field tells them apart. The handoff instruction forms an address from the rs1 value plus the sign-extended immediate, and gives that address to the accelerator as a pointer to its argument array. It then launches the accelerator with a start pulse. The return instruction sends the program counter to the address formed the same way.

While the accelerator holds control, the unit freezes every pipeline stage and gives the shared data-memory port to the accelerator. The port covers address, write data, write enable and the read-data route. When the accelerator reports done, the unit hands the port back and stops the stall. In the next cycle it redirects the program counter to the handoff instruction's PC plus the instruction size.

The controller has three states. `ST_IDLE` is the processor running normally. `ST_LAUNCH` is the single cycle carrying the start pulse. `ST_WAIT` holds the stall until done. The transitions are:
- *take-handoff*: `ST_IDLE` to `ST_LAUNCH`, on a valid handoff decode.
- *launched*: `ST_LAUNCH` to `ST_WAIT`, unconditionally.
- *finish*: `ST_WAIT` to `ST_IDLE`, when `acc_done` is high.

In every other case the state stays where it is. A return decode in `ST_IDLE` leaves the state unchanged and only arms a redirect.

Top module: `acc_handoff_ctrl`

## Requirements
- R1: After reset `acc_start`, `pipe_stall`, `dmem_sel_acc` and `pc_redir_valid` are all 0.
- R2: An instruction is custom when `dec_inst[6:0]` is 7'b0001011. The operation is chosen by `dec_inst[14:12]`: 3'b000 is handoff and 3'b001 is return. The immediate is `dec_inst[31:20]`. The rs1 value arrives on `dec_rs1`. An instruction counts only when `dec_valid` is 1.
- R3: One cycle after a handoff is decoded in idle, `acc_start` is high for exactly one cycle. From that cycle onward, `acc_arg_addr` equals rs1 plus the sign-extended immediate, and it stays stable while the stall lasts.
- R4: `pipe_stall` and `dmem_sel_acc` are high from the cycle after the handoff decode up to and including the cycle in which `acc_done` is sampled high in the waiting state. Both are low in the following cycle.
- R5: In the cycle after `acc_done` ends the wait, `pc_redir_valid` is high for one cycle, with `pc_redir_addr` equal to the handoff instruction's PC plus 4, wrapping modulo 2^32.
- R6: One cycle after a return is decoded in idle, `pc_redir_valid` is high for one cycle with `pc_redir_addr` equal to rs1 plus the sign-extended immediate. No stall and no start are produced.
- R7: A custom-0 instruction with any funct3 other than 000 or 001 produces no start, no stall and no redirect. So does any instruction with a different opcode.
- R8: Instructions presented while the accelerator holds control are ignored. `acc_done` is ignored in idle and in the start cycle.
- R9: Address sums use the sign-extended 12-bit immediate, so a negative immediate subtracts, and the sum wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode-stage instruction is valid |
| dec_inst | input | 32 | Decode-stage instruction word |
| dec_rs1 | input | 32 | Value of register rs1 |
| dec_pc | input | 32 | PC of the decode-stage instruction |
| acc_done | input | 1 | Accelerator finished its run |
| acc_start | output | 1 | One-cycle accelerator launch pulse |
| acc_arg_addr | output | 32 | Pointer to the accelerator argument array |
| pipe_stall | output | 1 | Freezes all pipeline stages |
| dmem_sel_acc | output | 1 | 1 gives the data-memory port to the accelerator |
| pc_redir_valid | output | 1 | One-cycle PC redirect request |
| pc_redir_addr | output | 32 | Redirect target |

## Verification
The bench builds the unit with its default parameters: a 32-bit datapath, a 12-bit immediate and a 4-byte instruction step. With these values the sign-extension boundary and the 32-bit wraparound of both address sums can be reached from small stimulus values. Handing off at the top of the address space reaches the PC+4 wrap, and a negative immediate reaches the subtract path. Waits of several lengths, together with done pulses in idle and in the start cycle, exercise every state transition and every case where an input is ignored.

// File: rtl/hoff_pkg.sv
package hoff_pkg;
    localparam logic [6:0] OPC_CUSTOM0 = 7'b0001011;
    localparam logic [2:0] F3_HANDOFF  = 3'b000;
    localparam logic [2:0] F3_RETURN   = 3'b001;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_WAIT
    } hoff_state_e;
endpackage

// File: rtl/hoff_decode.sv
module hoff_decode
    import hoff_pkg::*;
#(
    parameter int ILEN = 32
) (
    input  logic            valid,
    input  logic [ILEN-1:0] inst,
    output logic            is_handoff,
    output logic            is_return
);
    logic       custom_hit;
    logic       unused_fields;
    logic [2:0] f3;

    assign f3            = inst[14:12];
    assign custom_hit    = valid && (inst[6:0] == OPC_CUSTOM0);
    assign unused_fields = ^{inst[ILEN-1:15], inst[11:7]};

    always_comb begin
        is_handoff = 1'b0;
        is_return  = 1'b0;
        if (custom_hit) begin
            is_handoff = (f3 == F3_HANDOFF);
            is_return  = (f3 == F3_RETURN);
        end
    end
endmodule

// File: rtl/hoff_agen.sv
module hoff_agen #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 12
) (
    input  logic [XLEN-1:0]  base,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  sum
);
    localparam int EXT_W = XLEN - IMM_W;
    logic [XLEN-1:0] imm_sx;

    assign imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};
    assign sum    = base + imm_sx;
endmodule

// File: rtl/hoff_fsm.sv
module hoff_fsm
    import hoff_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int PC_STEP  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_handoff,
    input  logic            take_return,
    input  logic            acc_done,
    input  logic [XLEN-1:0] target,
    input  logic [XLEN-1:0] pc,
    output logic            start,
    output logic            stall,
    output logic            sel_acc,
    output logic            redir_valid,
    output logic [XLEN-1:0] redir_addr,
    output logic [XLEN-1:0] arg_addr
);
    localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

    hoff_state_e     state, state_nx;
    logic [XLEN-1:0] resume_pc;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (take_handoff) state_nx = ST_LAUNCH;
            ST_LAUNCH: state_nx = ST_WAIT;
            ST_WAIT:   if (acc_done) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        start   = 1'b0;
        stall   = 1'b0;
        sel_acc = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_LAUNCH: begin start = 1'b1; stall = 1'b1; sel_acc = 1'b1; end
            ST_WAIT:   begin stall = 1'b1; sel_acc = 1'b1; end
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_valid <= 1'b0;
            redir_addr  <= '0;
            arg_addr    <= '0;
            resume_pc   <= '0;
        end else begin
            redir_valid <= 1'b0;
            if (state == ST_IDLE && take_handoff) begin
                arg_addr  <= target;
                resume_pc <= pc + STEP;
            end else if (state == ST_IDLE && take_return) begin
                redir_valid <= 1'b1;
                redir_addr  <= target;
            end else if (state == ST_WAIT && acc_done) begin
                redir_valid <= 1'b1;
                redir_addr  <= resume_pc;
            end
        end
    end
endmodule

// File: rtl/acc_handoff_ctrl.sv
module acc_handoff_ctrl #(
    parameter int XLEN    = 32,
    parameter int IMM_W   = 12,
    parameter int PC_STEP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dec_valid,
    input  logic [31:0]     dec_inst,
    input  logic [XLEN-1:0] dec_rs1,
    input  logic [XLEN-1:0] dec_pc,
    input  logic            acc_done,
    output logic            acc_start,
    output logic [XLEN-1:0] acc_arg_addr,
    output logic            pipe_stall,
    output logic            dmem_sel_acc,
    output logic            pc_redir_valid,
    output logic [XLEN-1:0] pc_redir_addr
);
    logic            is_handoff, is_return;
    logic [XLEN-1:0] target;

    hoff_decode #(.ILEN(32)) u_dec (
        .valid      (dec_valid),
        .inst       (dec_inst),
        .is_handoff (is_handoff),
        .is_return  (is_return)
    );

    hoff_agen #(.XLEN(XLEN), .IMM_W(IMM_W)) u_agen (
        .base (dec_rs1),
        .imm  (dec_inst[31 -: IMM_W]),
        .sum  (target)
    );

    hoff_fsm #(.XLEN(XLEN), .PC_STEP(PC_STEP)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .take_handoff (is_handoff),
        .take_return  (is_return),
        .acc_done     (acc_done),
        .target       (target),
        .pc           (dec_pc),
        .start        (acc_start),
        .stall        (pipe_stall),
        .sel_acc      (dmem_sel_acc),
        .redir_valid  (pc_redir_valid),
        .redir_addr   (pc_redir_addr),
        .arg_addr     (acc_arg_addr)
    );
endmodule

// File: rtl/acc_handoff_ctrl_chk.sv
module acc_handoff_ctrl_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            acc_done,
    input logic            acc_start,
    input logic [XLEN-1:0] acc_arg_addr,
    input logic            pipe_stall,
    input logic            dmem_sel_acc,
    input logic            pc_redir_valid
);
    // R3: launch pulse lasts a single cycle
    p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_start |=> !acc_start);

    // R3: argument pointer held while the accelerator owns control
    p_arg_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_stall && !acc_start) |-> $stable(acc_arg_addr));

    // R4: a stall can only begin together with a launch
    p_stall_begins_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pipe_stall) |-> acc_start);

    // R4: done in wait ends stall and memory ownership next cycle
    p_done_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_stall && !acc_start && acc_done) |=> (!pipe_stall && !dmem_sel_acc));

    // R5: done in wait is followed by a redirect
    p_done_redirect_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_stall && !acc_start && acc_done) |=> pc_redir_valid);

    // R6: redirect never overlaps the stall
    p_redir_no_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pc_redir_valid |-> (!pipe_stall && !dmem_sel_acc));

    // R4: memory ownership and stall coincide
    p_sel_tracks_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_sel_acc |-> pipe_stall);
endmodule

bind acc_handoff_ctrl acc_handoff_ctrl_chk #(.XLEN(XLEN)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .acc_done       (acc_done),
    .acc_start      (acc_start),
    .acc_arg_addr   (acc_arg_addr),
    .pipe_stall     (pipe_stall),
    .dmem_sel_acc   (dmem_sel_acc),
    .pc_redir_valid (pc_redir_valid)
);

// File: tb/acc_handoff_ctrl_test.sv
`timescale 1ns/1ps
module acc_handoff_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 1'b0;
    logic [31:0] dec_inst = '0;
    logic [31:0] dec_rs1 = '0;
    logic [31:0] dec_pc = '0;
    logic        acc_done = 1'b0;
    logic        acc_start, pipe_stall, dmem_sel_acc, pc_redir_valid;
    logic [31:0] acc_arg_addr, pc_redir_addr;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    string ctx = "R1";

    // reference model state
    int          m_mode = 0;  // 0 idle, 1 launch cycle, 2 waiting
    logic        e_start = 0, e_redir = 0;
    logic [31:0] e_arg = 0, e_raddr = 0, m_resume = 0;

    always #5 clk = ~clk;

    acc_handoff_ctrl uut (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_inst(dec_inst),
        .dec_rs1(dec_rs1), .dec_pc(dec_pc), .acc_done(acc_done),
        .acc_start(acc_start), .acc_arg_addr(acc_arg_addr), .pipe_stall(pipe_stall),
        .dmem_sel_acc(dmem_sel_acc), .pc_redir_valid(pc_redir_valid),
        .pc_redir_addr(pc_redir_addr)
    );

    function automatic logic [31:0] sum_of(input logic [31:0] b, input logic [31:0] ins);
        int signed off;
        off = int'($signed(ins[31:20]));
        return b + 32'(off);
    endfunction

    always @(posedge clk) begin
        cyc++;
        e_start = 0;
        e_redir = 0;
        if (!rst_n) begin
            m_mode = 0;
        end else if (m_mode == 0) begin
            if (dec_valid && dec_inst[6:0] == 7'h0B && dec_inst[14:12] == 3'd0) begin
                m_mode = 1; e_start = 1;
                e_arg = sum_of(dec_rs1, dec_inst);
                m_resume = dec_pc + 32'd4;
            end else if (dec_valid && dec_inst[6:0] == 7'h0B && dec_inst[14:12] == 3'd1) begin
                e_redir = 1; e_raddr = sum_of(dec_rs1, dec_inst);
            end
        end else if (m_mode == 1) begin
            m_mode = 2;
        end else if (acc_done) begin
            m_mode = 0; e_redir = 1; e_raddr = m_resume;
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", ctx, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("start", 32'(acc_start), 32'(e_start));
            chk("stall", 32'(pipe_stall), 32'(m_mode != 0));
            chk("sel", 32'(dmem_sel_acc), 32'(m_mode != 0));
            chk("redir_valid", 32'(pc_redir_valid), 32'(e_redir));
            if (e_redir) chk("redir_addr", pc_redir_addr, e_raddr);
            if (m_mode != 0) chk("arg_addr", acc_arg_addr, e_arg);
        end
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected below 20000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] mk(input logic [11:0] imm, input logic [2:0] f3,
                                       input logic [6:0] opc);
        return {imm, 5'd3, f3, 5'd0, opc};
    endfunction

    task automatic issue(input logic [31:0] ins, input logic [31:0] rs1, input logic [31:0] pc);
        @(negedge clk);
        dec_valid = 1; dec_inst = ins; dec_rs1 = rs1; dec_pc = pc;
        @(negedge clk);
        dec_valid = 0; dec_inst = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_done;
        @(negedge clk); acc_done = 1;
        @(negedge clk); acc_done = 0;
    endtask

    initial begin
        idle(3);
        @(negedge clk);
        // R1: outputs idle straight after reset
        ctx = "R1";
        chk("reset start", 32'(acc_start), 0);
        chk("reset stall", 32'(pipe_stall), 0);
        chk("reset sel", 32'(dmem_sel_acc), 0);
        chk("reset redir", 32'(pc_redir_valid), 0);
        rst_n = 1;
        idle(2);

        // R2 R3 R4 R5: handoff, positive immediate, short wait
        ctx = "R3";
        issue(mk(12'h010, 3'd0, 7'h0B), 32'h0000_1000, 32'h0000_0200);
        ctx = "R4";
        idle(4);
        pulse_done();
        ctx = "R5";
        idle(3);

        // R6 R9: return with negative immediate
        ctx = "R6";
        issue(mk(12'hFF0, 3'd1, 7'h0B), 32'h0000_0100, 32'h0000_0300);
        idle(2);

        // R7: other funct3 under custom-0 and a foreign opcode
        ctx = "R7";
        issue(mk(12'h004, 3'd2, 7'h0B), 32'h10, 32'h40);
        issue(mk(12'h004, 3'd7, 7'h0B), 32'h10, 32'h44);
        issue(mk(12'h004, 3'd0, 7'h13), 32'h10, 32'h48);
        issue(mk(12'h004, 3'd1, 7'h33), 32'h10, 32'h4C);
        idle(2);

        // R8: done while idle ignored
        ctx = "R8";
        pulse_done();
        idle(2);

        // R8: done in start cycle ignored, decodes during wait ignored
        @(negedge clk);
        dec_valid = 1; dec_inst = mk(12'h7FF, 3'd0, 7'h0B); dec_rs1 = 32'h2000; dec_pc = 32'h500;
        @(negedge clk);
        dec_valid = 0; acc_done = 1;
        @(negedge clk);
        acc_done = 0;
        issue(mk(12'h020, 3'd1, 7'h0B), 32'h9000, 32'h504);
        issue(mk(12'h020, 3'd0, 7'h0B), 32'h9000, 32'h508);
        idle(3);
        pulse_done();
        idle(3);

        // R9 R5: wraparound of both sums
        ctx = "R9";
        issue(mk(12'h020, 3'd0, 7'h0B), 32'hFFFF_FFF0, 32'hFFFF_FFFC);
        idle(1);
        pulse_done();
        idle(2);
        issue(mk(12'h800, 3'd1, 7'h0B), 32'h0000_0100, 32'h10);
        idle(3);

        // R4: longer wait
        ctx = "R4";
        issue(mk(12'h000, 3'd0, 7'h0B), 32'hABCD_0000, 32'h0000_0800);
        idle(30);
        pulse_done();
        idle(3);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule